// File: doc/BRIEF.md
# Always-on wakeup interrupt controller

This block sits in an always-on power domain. It does two jobs. First, it conditions one external non-maskable interrupt pin. Software picks whether the pin triggers on a level or on an edge. The block holds the result in a pending latch, and the enable bit of that slot gates the latch output to one line of the main interrupt distributor. Second, it collects up to 64 interrupt slots and combines them into a single level interrupt for a management coprocessor.

Slot 0 is the pin. Slots 1 to 15 are direct inputs. Each direct input goes straight to the distributor and is also sampled locally. The next 16 slots take the coprocessor's copies of banked peripheral interrupts. Each remaining slot has a 7-bit selector that picks one of 128 shared peripheral lines. Every input passes through a two-flop synchronizer before it reaches a pending bit. Software uses a small word-addressed register bus to set enables, masks, the pin trigger type and the selectors, and to read and clear pending bits.

Top module: `aon_wake_intc`

## Requirements
- R1: After reset, all pending, enable and mask bits read 0, the trigger field reads 3 (rising edge), every selector reads 0, `copIrq` is 0 and `distOut[0]` is 0.
- R2: The trigger field at word address 0x01 (bits 1:0) selects the slot 0 condition: 0 pin low, 1 falling edge, 2 pin high, 3 rising edge. A pin change reaches the slot 0 pending bit on the third rising clock edge after it, not earlier.
- R3: In the edge modes, slot 0 pending stays set until a write to pending word 0 (address 0x02) with bit 0 at 1. If that clearing write lands in the same cycle as a new edge, the bit stays set.
- R4: In the level modes, slot 0 pending follows the conditioned pin. A clearing write has no lasting effect while the pin stays active.
- R5: `distOut[0]` equals slot 0 pending ANDed with enable bit 0. Clearing enable bit 0 takes the line low.
- R6: `distOut[15:1]` equals `directIn` combinationally, whatever the enable and mask bits hold.
- R7: Pending bits 1 to 15 follow the synchronized direct inputs, and bits 16 to 31 follow the synchronized banked inputs. Both use the same three-edge latency.
- R8: Slot 32+i takes the synchronized shared line chosen by the 7-bit selector at word address 0x20+i, for i from 0 to 31.
- R9: `copIrq` is 1 exactly when some slot is pending, enabled and not masked. A mask bit at 1 blocks its slot.
- R10: Pending reads at 0x02/0x03, enable at 0x04/0x05 and mask at 0x06/0x07. The low word holds slots 0 to 31. Enable, mask, trigger and selectors read back what was written.
- R11: Any write to the trigger register clears slot 0 pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 6 | Register word address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| nmiPin | input | 1 | External non-maskable interrupt pin |
| directIn | input | 15 | Direct interrupt inputs, slots 1 to 15 |
| bankedIn | input | 16 | Banked peripheral copies, slots 16 to 31 |
| spiIn | input | 128 | Shared peripheral lines feeding the selectors |
| distOut | output | 16 | Lines to the main distributor: gated slot 0 and raw direct inputs |
| copIrq | output | 1 | Combined coprocessor interrupt level |

## Verification
The bench builds the block with its default parameters: 64 slots, 15 direct inputs, 16 banked inputs, 32 selected slots and 128 shared lines. With these values both register words are exercised, and the highest selected slot can pick the top shared line (selector value 127). Random rounds set every selector, enable and mask. Directed cases cover all four trigger modes, the third-edge latency, a clearing write that collides with an edge, and enable gating of the distributor line.

// File: rtl/aon_intc_pkg.sv
package aon_intc_pkg;
  localparam int WORD_W    = 32;
  localparam int ADDR_W    = 6;
  localparam int MAX_WORDS = 2;

  localparam logic [ADDR_W-1:0] ADDR_MODE = 6'h01;
  localparam logic [ADDR_W-1:0] ADDR_PEND = 6'h02;
  localparam logic [ADDR_W-1:0] ADDR_EN   = 6'h04;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 6'h06;
  localparam logic [ADDR_W-1:0] ADDR_SEL  = 6'h20;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_FALL = 2'b01,
    TRIG_HIGH = 2'b10,
    TRIG_RISE = 2'b11
  } trig_e;

  typedef struct packed {
    logic nmiClr;
    logic modeWr;
  } strobe_t;
endpackage

// File: rtl/aon_intc_sync.sv
module aon_intc_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/aon_intc_ctrl.sv
module aon_intc_ctrl
  import aon_intc_pkg::*;
#(
  parameter int NUM_SLOTS = 64,
  parameter int NUM_MUX   = 32,
  parameter int SEL_W     = 7
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     regWe,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic [WORD_W-1:0]        regWdata,
  input  logic [NUM_SLOTS-1:0]     pendAll,
  output logic [WORD_W-1:0]        regRdata,
  output logic [NUM_SLOTS-1:0]     enAll,
  output logic [NUM_SLOTS-1:0]     maskAll,
  output trig_e                    nmiMode,
  output logic [NUM_MUX*SEL_W-1:0] selFlat,
  output strobe_t                  strobe
);
  localparam int NUM_WORDS = NUM_SLOTS / WORD_W;

  logic [SEL_W-1:0] selReg [NUM_MUX];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enAll   <= '0;
      maskAll <= '0;
      nmiMode <= TRIG_RISE;
      for (int i = 0; i < NUM_MUX; i++) selReg[i] <= '0;
    end else if (regWe) begin
      if (regAddr == ADDR_MODE) nmiMode <= trig_e'(regWdata[1:0]);
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (regAddr == ADDR_EN + ADDR_W'(w))   enAll[w*WORD_W +: WORD_W]   <= regWdata;
        if (regAddr == ADDR_MASK + ADDR_W'(w)) maskAll[w*WORD_W +: WORD_W] <= regWdata;
      end
      for (int i = 0; i < NUM_MUX; i++) begin
        if (regAddr == ADDR_SEL + ADDR_W'(i)) selReg[i] <= regWdata[SEL_W-1:0];
      end
    end
  end

  for (genvar g = 0; g < NUM_MUX; g++) begin : gSelFlat
    assign selFlat[g*SEL_W +: SEL_W] = selReg[g];
  end

  always_comb begin
    strobe.nmiClr = regWe && (regAddr == ADDR_PEND) && regWdata[0];
    strobe.modeWr = regWe && (regAddr == ADDR_MODE);
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == ADDR_MODE) regRdata = WORD_W'(nmiMode);
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (regAddr == ADDR_PEND + ADDR_W'(w)) regRdata = pendAll[w*WORD_W +: WORD_W];
      if (regAddr == ADDR_EN + ADDR_W'(w))   regRdata = enAll[w*WORD_W +: WORD_W];
      if (regAddr == ADDR_MASK + ADDR_W'(w)) regRdata = maskAll[w*WORD_W +: WORD_W];
    end
    for (int i = 0; i < NUM_MUX; i++) begin
      if (regAddr == ADDR_SEL + ADDR_W'(i)) regRdata = WORD_W'(selReg[i]);
    end
  end
endmodule

// File: rtl/aon_intc_datapath.sv
module aon_intc_datapath
  import aon_intc_pkg::*;
#(
  parameter int NUM_SLOTS  = 64,
  parameter int NUM_DIRECT = 15,
  parameter int NUM_BANKED = 16,
  parameter int NUM_MUX    = 32,
  parameter int SPI_LINES  = 128,
  parameter int SEL_W      = 7
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     nmiPin,
  input  logic [NUM_DIRECT-1:0]    directIn,
  input  logic [NUM_BANKED-1:0]    bankedIn,
  input  logic [SPI_LINES-1:0]     spiIn,
  input  trig_e                    nmiMode,
  input  logic [NUM_MUX*SEL_W-1:0] selFlat,
  input  logic [NUM_SLOTS-1:0]     enAll,
  input  logic [NUM_SLOTS-1:0]     maskAll,
  input  strobe_t                  strobe,
  output logic [NUM_SLOTS-1:0]     pendAll,
  output logic [NUM_DIRECT:0]      distOut,
  output logic                     copIrq,
  output logic                     edgePulse,
  output logic                     nmiSync
);
  localparam int BANK_HI = NUM_DIRECT + NUM_BANKED;
  localparam int SYNC_W  = 1 + BANK_HI + SPI_LINES;

  logic [SYNC_W-1:0]      rawBus;
  logic [SYNC_W-1:0]      syncBus;
  logic [SPI_LINES-1:0]   spiSync;
  logic [NUM_SLOTS-1:1]   slotLevel;
  logic [NUM_SLOTS-1:1]   pendHi;
  logic                   pend0;
  logic                   nmiPrev;
  logic                   levelCond;
  logic                   isEdge;

  assign rawBus = {spiIn, bankedIn, directIn, nmiPin};

  aon_intc_sync #(.WIDTH(SYNC_W)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .din  (rawBus),
    .dout (syncBus)
  );

  assign nmiSync = syncBus[0];
  assign spiSync = syncBus[SYNC_W-1:BANK_HI+1];
  assign slotLevel[BANK_HI:1] = syncBus[BANK_HI:1];

  for (genvar g = 0; g < NUM_MUX; g++) begin : gMux
    assign slotLevel[BANK_HI+1+g] = spiSync[selFlat[g*SEL_W +: SEL_W]];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) nmiPrev <= 1'b0;
    else       nmiPrev <= nmiSync;
  end

  always_comb begin
    isEdge    = nmiMode[0];
    edgePulse = 1'b0;
    levelCond = 1'b0;
    unique case (nmiMode)
      TRIG_LOW:  levelCond = ~nmiSync;
      TRIG_HIGH: levelCond = nmiSync;
      TRIG_FALL: edgePulse = nmiPrev & ~nmiSync;
      TRIG_RISE: edgePulse = ~nmiPrev & nmiSync;
      default:   edgePulse = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              pend0 <= 1'b0;
    else if (strobe.modeWr) pend0 <= 1'b0;
    else if (isEdge)        pend0 <= edgePulse | (pend0 & ~strobe.nmiClr);
    else                    pend0 <= levelCond;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendHi <= '0;
    else       pendHi <= slotLevel;
  end

  assign pendAll = {pendHi, pend0};
  assign distOut = {directIn, pend0 & enAll[0]};
  assign copIrq  = |(pendAll & enAll & ~maskAll);
endmodule

// File: rtl/aon_wake_intc.sv
module aon_wake_intc
  import aon_intc_pkg::*;
#(
  parameter int NUM_SLOTS  = 64,
  parameter int NUM_DIRECT = 15,
  parameter int NUM_BANKED = 16,
  parameter int SPI_LINES  = 128
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWe,
  input  logic [5:0]            regAddr,
  input  logic [31:0]           regWdata,
  output logic [31:0]           regRdata,
  input  logic                  nmiPin,
  input  logic [NUM_DIRECT-1:0] directIn,
  input  logic [NUM_BANKED-1:0] bankedIn,
  input  logic [SPI_LINES-1:0]  spiIn,
  output logic [NUM_DIRECT:0]   distOut,
  output logic                  copIrq
);
  localparam int NUM_MUX = NUM_SLOTS - 1 - NUM_DIRECT - NUM_BANKED;
  localparam int SEL_W   = $clog2(SPI_LINES);

  logic [NUM_SLOTS-1:0]     pendAll;
  logic [NUM_SLOTS-1:0]     enAll;
  logic [NUM_SLOTS-1:0]     maskAll;
  logic [NUM_MUX*SEL_W-1:0] selFlat;
  trig_e                    nmiMode;
  strobe_t                  strobe;
  logic                     edgePulse;
  logic                     nmiSync;

  aon_intc_ctrl #(
    .NUM_SLOTS (NUM_SLOTS),
    .NUM_MUX   (NUM_MUX),
    .SEL_W     (SEL_W)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .pendAll  (pendAll),
    .regRdata (regRdata),
    .enAll    (enAll),
    .maskAll  (maskAll),
    .nmiMode  (nmiMode),
    .selFlat  (selFlat),
    .strobe   (strobe)
  );

  aon_intc_datapath #(
    .NUM_SLOTS  (NUM_SLOTS),
    .NUM_DIRECT (NUM_DIRECT),
    .NUM_BANKED (NUM_BANKED),
    .NUM_MUX    (NUM_MUX),
    .SPI_LINES  (SPI_LINES),
    .SEL_W      (SEL_W)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .nmiPin    (nmiPin),
    .directIn  (directIn),
    .bankedIn  (bankedIn),
    .spiIn     (spiIn),
    .nmiMode   (nmiMode),
    .selFlat   (selFlat),
    .enAll     (enAll),
    .maskAll   (maskAll),
    .strobe    (strobe),
    .pendAll   (pendAll),
    .distOut   (distOut),
    .copIrq    (copIrq),
    .edgePulse (edgePulse),
    .nmiSync   (nmiSync)
  );
endmodule

// File: rtl/aon_intc_chk.sv
module aon_intc_chk
  import aon_intc_pkg::*;
#(
  parameter int NUM_SLOTS = 64
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 regWe,
  input logic [5:0]           regAddr,
  input logic                 regWdata0,
  input logic [1:0]           nmiMode,
  input logic [NUM_SLOTS-1:0] pendAll,
  input logic [NUM_SLOTS-1:0] enAll,
  input logic [NUM_SLOTS-1:0] maskAll,
  input logic                 distOut0,
  input logic                 copIrq,
  input logic                 edgePulse,
  input logic                 nmiSync
);
  logic modeWrite;
  logic clrWrite;
  assign modeWrite = regWe && (regAddr == ADDR_MODE);
  assign clrWrite  = regWe && (regAddr == ADDR_PEND) && regWdata0;

  a_r5_gate_off: assert property (@(posedge clk) disable iff (!rstN)
    !enAll[0] |-> !distOut0);

  a_r5_gate_on: assert property (@(posedge clk) disable iff (!rstN)
    (enAll[0] && pendAll[0]) |-> distOut0);

  a_r9_no_enable: assert property (@(posedge clk) disable iff (!rstN)
    (enAll == '0) |-> !copIrq);

  a_r9_all_masked: assert property (@(posedge clk) disable iff (!rstN)
    (&maskAll) |-> !copIrq);

  a_r3_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (edgePulse && !modeWrite) |=> pendAll[0]);

  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    (nmiMode[0] && pendAll[0] && !clrWrite && !modeWrite) |=> pendAll[0]);

  a_r2_edge_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (nmiMode[0] && !edgePulse && !pendAll[0]) |=> !pendAll[0]);

  a_r4_level_follow: assert property (@(posedge clk) disable iff (!rstN)
    (!nmiMode[0] && (nmiSync == nmiMode[1]) && !modeWrite) |=> pendAll[0]);

  a_r11_mode_clear: assert property (@(posedge clk) disable iff (!rstN)
    modeWrite |=> !pendAll[0]);
endmodule

bind aon_wake_intc aon_intc_chk #(.NUM_SLOTS(NUM_SLOTS)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .regWe     (regWe),
  .regAddr   (regAddr),
  .regWdata0 (regWdata[0]),
  .nmiMode   (nmiMode),
  .pendAll   (pendAll),
  .enAll     (enAll),
  .maskAll   (maskAll),
  .distOut0  (distOut[0]),
  .copIrq    (copIrq),
  .edgePulse (edgePulse),
  .nmiSync   (nmiSync)
);

// File: tb/aon_wake_intc_test.sv
module aon_wake_intc_test;
  localparam int CLK_PERIOD = 10;
  localparam int NSEL = 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         regWe = 1'b0;
  logic [5:0]   regAddr = '0;
  logic [31:0]  regWdata = '0;
  logic [31:0]  regRdata;
  logic         nmiPin = 1'b0;
  logic [14:0]  directIn = '0;
  logic [15:0]  bankedIn = '0;
  logic [127:0] spiIn = '0;
  logic [15:0]  distOut;
  logic         copIrq;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [6:0] selM [NSEL];

  always #(CLK_PERIOD/2) clk = ~clk;

  aon_wake_intc uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .nmiPin(nmiPin),
    .directIn(directIn), .bankedIn(bankedIn), .spiIn(spiIn),
    .distOut(distOut), .copIrq(copIrq)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [63:0] expSlots(input logic [14:0] dIn, input logic [15:0] bIn,
                                           input logic [127:0] sIn);
    logic [63:0] r;
    r = '0;
    r[15:1]  = dIn;
    r[31:16] = bIn;
    for (int i = 0; i < NSEL; i++) r[32+i] = sIn[selM[i]];
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, lo, hi;
    logic [63:0] en64, mk64, exp64;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < NSEL; i++) selM[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(6'h02, v); check("R1 pend lo", v, 0);
    rd(6'h03, v); check("R1 pend hi", v, 0);
    rd(6'h04, v); check("R1 en lo", v, 0);
    rd(6'h07, v); check("R1 mask hi", v, 0);
    rd(6'h01, v); check("R1 mode", v, 3);
    rd(6'h3f, v); check("R1 sel31", v, 0);
    check("R1 copIrq", copIrq, 0);
    check("R1 distOut0", distOut[0], 0);

    // R10 readback
    wr(6'h05, 32'hA5A5_0F0F); rd(6'h05, v); check("R10 en hi", v, 32'hA5A5_0F0F);
    wr(6'h06, 32'h1234_5678); rd(6'h06, v); check("R10 mask lo", v, 32'h1234_5678);
    wr(6'h25, 32'hFFFF_FF55); rd(6'h25, v); check("R10 sel5", v, 32'h55);
    selM[5] = 7'h55;
    wr(6'h05, 0); wr(6'h06, 0);

    // R6 direct pass-through, independent of enable
    @(negedge clk); directIn = 15'h2B4D; #1;
    check("R6 direct en0", distOut[15:1], 15'h2B4D);
    wr(6'h04, 32'hFFFF_FFFE);
    directIn = 15'h54B2; #1;
    check("R6 direct en1", distOut[15:1], 15'h54B2);
    directIn = '0;

    // R2 rising edge latency, R5 gating
    wr(6'h04, 32'h1);
    @(negedge clk); nmiPin = 1'b1;
    repeat (2) @(posedge clk); @(negedge clk);
    rd(6'h02, v);
    // rd consumed another negedge: third posedge has passed now
    check("R2 rise latched", v[0], 1);
    check("R5 dist on", distOut[0], 1);
    @(negedge clk); nmiPin = 1'b0; settle();
    rd(6'h02, v); check("R3 edge hold", v[0], 1);
    wr(6'h04, 32'h0); #1; check("R5 dist gated", distOut[0], 0);
    wr(6'h04, 32'h1);
    wr(6'h02, 32'h1); rd(6'h02, v); check("R3 w1c", v[0], 0);

    // R2 exact latency: not yet after two edges
    @(negedge clk); nmiPin = 1'b1;
    repeat (2) @(posedge clk); #1;
    check("R2 not early", uut.distOut[0], 0);
    // R3 collision: clear write in the same cycle as the edge
    @(negedge clk); regWe = 1'b1; regAddr = 6'h02; regWdata = 32'h1;
    @(negedge clk); regWe = 1'b0;
    rd(6'h02, v); check("R3 set wins", v[0], 1);

    // R11 mode write clears, R2 falling edge
    wr(6'h01, 32'h1); rd(6'h02, v); check("R11 mode clears", v[0], 0);
    @(negedge clk); nmiPin = 1'b0; settle();
    rd(6'h02, v); check("R2 fall latched", v[0], 1);

    // R4 level high
    wr(6'h01, 32'h2); settle();
    rd(6'h02, v); check("R4 high idle", v[0], 0);
    @(negedge clk); nmiPin = 1'b1; settle();
    rd(6'h02, v); check("R4 high active", v[0], 1);
    wr(6'h02, 32'h1); rd(6'h02, v); check("R4 reasserts", v[0], 1);
    @(negedge clk); nmiPin = 1'b0; settle();
    rd(6'h02, v); check("R4 follows", v[0], 0);

    // R2 level low
    wr(6'h01, 32'h0); settle();
    rd(6'h02, v); check("R2 low active", v[0], 1);
    wr(6'h01, 32'h3); settle();
    rd(6'h02, v); check("R2 rise idle", v[0], 0);

    // random rounds: R7 R8 R9
    for (int it = 0; it < 30; it++) begin
      @(negedge clk);
      directIn = 15'($urandom);
      bankedIn = 16'($urandom);
      spiIn = {$urandom, $urandom, $urandom, $urandom};
      for (int i = 0; i < NSEL; i++) begin
        selM[i] = 7'($urandom);
        wr(6'h20 + 6'(i), 32'(selM[i]));
      end
      en64 = {$urandom, $urandom};
      mk64 = {$urandom, $urandom} | {$urandom, $urandom};
      if (it % 5 == 0) en64 = '0;
      wr(6'h04, en64[31:0]); wr(6'h05, en64[63:32]);
      wr(6'h06, mk64[31:0]); wr(6'h07, mk64[63:32]);
      settle();
      exp64 = expSlots(directIn, bankedIn, spiIn);
      rd(6'h02, lo); rd(6'h03, hi);
      check("R7 direct+banked pend", {32'h0, lo}, {32'h0, exp64[31:0]});
      check("R8 muxed pend", {32'h0, hi}, {32'h0, exp64[63:32]});
      check("R9 copIrq", copIrq, |(exp64 & en64 & ~mk64));
    end

    // R8 top selector picks top line
    @(negedge clk); directIn = '0; bankedIn = '0; spiIn = '0; spiIn[127] = 1'b1;
    for (int i = 0; i < NSEL; i++) begin
      selM[i] = 7'd0; wr(6'h20 + 6'(i), 0);
    end
    wr(6'h3f, 32'd127); settle();
    rd(6'h03, v); check("R8 sel127", v, 32'h8000_0000);

    // R9 mask blocks, unmask releases
    wr(6'h05, 32'hFFFF_FFFF); wr(6'h07, 32'hFFFF_FFFF);
    wr(6'h04, 0); wr(6'h06, 32'hFFFF_FFFF); #1;
    check("R9 masked", copIrq, 0);
    wr(6'h07, 32'h7FFF_FFFF); #1;
    check("R9 unmasked", copIrq, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule